// File: doc/BRIEF.md
# Virtual-Machine Integer Execution Unit

This unit executes one integer arithmetic or logic operation of a 64-bit register virtual machine for each accepted request. A request carries an 8-bit opcode, a width-class bit (32-bit or 64-bit operation), the current destination register value, the source register value, a 32-bit immediate and a 16-bit offset field. The unit selects and widens the second operand. It evaluates add, subtract, OR, AND, XOR, move, sign-extending move and the three shifts. It then returns the value to be written back to the destination register, registered one cycle after the request.

Divide and modulo are computed by a separate divider. For these operations the unit only prepares the divisor operand and flags whether the operation is signed, then hands both over. Malformed requests never corrupt the destination. These are a bad offset, an offset on an operation that takes none, or an operation code outside the unit's set. Each raises an illegal flag and passes the destination value through untouched.

Control is a two-state machine. `ST_IDLE` means no result is presented. `ST_DONE` means a result is presented for this cycle. The transitions are:
- IDLE→DONE when `in_valid` is high.
- DONE→DONE on back-to-back requests.
- DONE→IDLE when `in_valid` is low.
- IDLE→IDLE otherwise.

Top module: `vm_alu_unit`

## Requirements
- R1: After reset, `out_valid`, `out_dst`, `out_illegal`, `out_div_req`, `out_div_signed` and `out_div_opnd` are all 0. A request with `in_valid` high is captured at the clock edge and presented with `out_valid` high in the next cycle. Without `in_valid`, `out_valid` is low and all result outputs hold their values.
- R2: `opcode[7:4]` is the operation code: 0x0 add, 0x1 subtract, 0x3 divide, 0x4 OR, 0x5 AND, 0x6 left shift, 0x7 logical right shift, 0x9 modulo, 0xa XOR, 0xb move, 0xc arithmetic right shift. `opcode[3]` = 1 selects the source register as the second operand and 0 selects the immediate. `opcode[2:0]` is ignored.
- R3: Add and subtract wrap silently modulo 2^64 (64-bit class) or 2^32 (32-bit class). OR, AND and XOR are bitwise.
- R4: `op_wide` = 1 selects the 64-bit class and 0 the 32-bit class. In the 32-bit class only the low 32 bits of the source register are used, and bits 63:32 of every legal result are 0.
- R5: In the 64-bit class the immediate is sign-extended from 32 to 64 bits. In the 32-bit class it is used as its 32 bits.
- R6: Left shift and logical right shift use the second operand masked with 0x3F (64-bit class) or 0x1F (32-bit class) as the shift amount. A 32-bit logical right shift fills with zeros from bit 31.
- R7: Arithmetic right shift replicates bit 63 of the destination (64-bit class) or bit 31 (32-bit class, result zero-filled above bit 31).
- R8: Move with offset 0 writes the second operand.
- R9: Move with offset 8, 16 or 32 in the 64-bit class writes that many low bits of the second operand, sign-extended to 64 bits.
- R10: Move with offset 8 or 16 in the 32-bit class sign-extends to 32 bits and clears bits 63:32. Offset 32 in the 32-bit class is illegal.
- R11: Divide or modulo with offset 0 raises `out_div_req` with `out_div_signed` = 0. With offset 1 it raises `out_div_req` with `out_div_signed` = 1. `out_div_opnd` carries the prepared second operand, and `out_dst` carries the destination (zero-filled above bit 31 in the 32-bit class).
- R12: Any other offset on move, divide or modulo, a non-zero offset on any other operation, or operation code 0x2, 0x8, 0xd, 0xe or 0xf sets `out_illegal`. It also returns the destination value unchanged in all 64 bits and keeps `out_div_req` and `out_div_opnd` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| opcode | input | 8 | Operation code [7:4], operand select [3] |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| offset | input | 16 | Offset field (move width / divide signedness) |
| out_valid | output | 1 | Result presented this cycle |
| out_dst | output | 64 | Value to write back to the destination |
| out_illegal | output | 1 | Request was malformed |
| out_div_req | output | 1 | Divide/modulo to be performed by the divider |
| out_div_signed | output | 1 | Divide/modulo is signed |
| out_div_opnd | output | 64 | Prepared divisor operand |

## Verification
Two functions can decide the result of the same request. One is the 32-bit zero-fill of the upper half. The other is the illegal-request pass-through, which must keep the upper half intact. The bench provokes both with a 32-bit-class move using offset 32 on a destination whose upper half is non-zero. It judges the request correct only if all 64 destination bits return unchanged with the illegal flag set. It sends that request back-to-back with a legal 32-bit add, so the flag and the zero-fill must also switch in consecutive cycles without carrying over.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

    typedef logic [3:0] opc_t;

    localparam opc_t OPC_ADD  = 4'h0;
    localparam opc_t OPC_SUB  = 4'h1;
    localparam opc_t OPC_DIV  = 4'h3;
    localparam opc_t OPC_OR   = 4'h4;
    localparam opc_t OPC_AND  = 4'h5;
    localparam opc_t OPC_LSH  = 4'h6;
    localparam opc_t OPC_RSH  = 4'h7;
    localparam opc_t OPC_MOD  = 4'h9;
    localparam opc_t OPC_XOR  = 4'ha;
    localparam opc_t OPC_MOV  = 4'hb;
    localparam opc_t OPC_ARSH = 4'hc;

    // position of the operand-select bit inside the 8-bit opcode
    localparam int SEL_BIT = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } unit_state_e;

endpackage

// File: rtl/vm_operand_prep.sv
module vm_operand_prep #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              wide,
    input  logic              use_reg,
    input  logic [DATA_W-1:0] src,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;
    logic [DATA_W-1:0] src_lo;

    assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign imm_zx = {{EXT_W{1'b0}}, imm};
    assign src_lo = {{HALF_W{1'b0}}, src[HALF_W-1:0]};

    always_comb begin
        unique case ({use_reg, wide})
            2'b11:   opnd_b = src;
            2'b10:   opnd_b = src_lo;
            2'b01:   opnd_b = imm_sx;
            default: opnd_b = imm_zx;
        endcase
    end

endmodule

// File: rtl/vm_alu_core.sv
module vm_alu_core
    import vm_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic              wide,
    input  opc_t              opc,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              illegal,
    output logic              div_req,
    output logic              div_signed
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int SX_N   = 3;

    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] sx [SX_N];
    logic [DATA_W-1:0] raw;
    logic              bad;
    logic              dreq;
    logic              dsig;
    logic              off_zero;
    logic signed [DATA_W-1:0] a_s;
    logic signed [HALF_W-1:0] a_lo_s;
    logic signed [HALF_W-1:0] arsh_lo;
    logic signed [DATA_W-1:0] arsh_full;
    logic [HALF_W-1:0]        rsh_lo;

    assign shamt    = wide ? b[SH_W-1:0] : {1'b0, b[SH_W-2:0]};
    assign off_zero = (off == '0);
    assign a_s      = a;
    assign a_lo_s   = a[HALF_W-1:0];
    assign arsh_lo  = a_lo_s >>> shamt;
    assign arsh_full = a_s >>> shamt;
    assign rsh_lo   = a[HALF_W-1:0] >> shamt;

    // sign-extended copies of the 8, 16 and 32 low bits of operand b
    for (genvar g = 0; g < SX_N; g++) begin : g_sx
        localparam int W = 8 << g;
        assign sx[g] = {{(DATA_W-W){b[W-1]}}, b[W-1:0]};
    end

    always_comb begin
        raw  = '0;
        bad  = 1'b0;
        dreq = 1'b0;
        dsig = 1'b0;
        case (opc)
            OPC_ADD:  begin raw = a + b;  bad = !off_zero; end
            OPC_SUB:  begin raw = a - b;  bad = !off_zero; end
            OPC_OR:   begin raw = a | b;  bad = !off_zero; end
            OPC_AND:  begin raw = a & b;  bad = !off_zero; end
            OPC_XOR:  begin raw = a ^ b;  bad = !off_zero; end
            OPC_LSH:  begin raw = a << shamt; bad = !off_zero; end
            OPC_RSH: begin
                raw = wide ? (a >> shamt) : {{HALF_W{1'b0}}, rsh_lo};
                bad = !off_zero;
            end
            OPC_ARSH: begin
                raw = wide ? DATA_W'(arsh_full) : {{HALF_W{1'b0}}, arsh_lo};
                bad = !off_zero;
            end
            OPC_MOV: begin
                if (off_zero)                          raw = b;
                else if (off == OFF_W'(8))             raw = sx[0];
                else if (off == OFF_W'(16))            raw = sx[1];
                else if (off == OFF_W'(32) && wide)    raw = sx[2];
                else                                   bad = 1'b1;
            end
            OPC_DIV, OPC_MOD: begin
                raw = a;
                if (off_zero) begin
                    dreq = 1'b1;
                end else if (off == OFF_W'(1)) begin
                    dreq = 1'b1;
                    dsig = 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end
            default: bad = 1'b1;
        endcase
    end

    always_comb begin
        if (bad)       res = a;
        else if (wide) res = raw;
        else           res = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        illegal    = bad;
        div_req    = dreq & !bad;
        div_signed = dsig & !bad;
    end

endmodule

// File: rtl/vm_alu_unit.sv
module vm_alu_unit
    import vm_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16,
    parameter int OPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_wide,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [OFF_W-1:0]  offset,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_dst,
    output logic              out_illegal,
    output logic              out_div_req,
    output logic              out_div_signed,
    output logic [DATA_W-1:0] out_div_opnd
);
    localparam int HALF_W = DATA_W / 2;

    unit_state_e       state_q, state_d;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] core_res;
    logic              core_illegal;
    logic              core_div_req;
    logic              core_div_signed;
    opc_t              opc;

    assign opc = opcode[OPC_W-1:OPC_W-4];

    vm_operand_prep #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_prep (
        .wide    (op_wide),
        .use_reg (opcode[SEL_BIT]),
        .src     (src_val),
        .imm     (imm),
        .opnd_b  (opnd_b)
    );

    vm_alu_core #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_core (
        .wide       (op_wide),
        .opc        (opc),
        .off        (offset),
        .a          (dst_val),
        .b          (opnd_b),
        .res        (core_res),
        .illegal    (core_illegal),
        .div_req    (core_div_req),
        .div_signed (core_div_signed)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers, loaded on an accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_dst        <= '0;
            out_illegal    <= 1'b0;
            out_div_req    <= 1'b0;
            out_div_signed <= 1'b0;
            out_div_opnd   <= '0;
        end else if (in_valid) begin
            out_dst        <= core_res;
            out_illegal    <= core_illegal;
            out_div_req    <= core_div_req;
            out_div_signed <= core_div_signed;
            out_div_opnd   <= core_div_req ? opnd_b : '0;
        end
    end

    // output decode of the state
    always_comb begin
        unique case (state_q)
            ST_DONE: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_dst));

    // R12
    illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && core_illegal |=> out_illegal && out_dst == $past(dst_val));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !op_wide && !core_illegal |=> out_dst[DATA_W-1:HALF_W] == '0);

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_illegal, out_div_req}));

    // R11
    div_opnd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_div_req |-> out_div_opnd == '0 && !out_div_signed);

endmodule

// File: tb/vm_alu_unit_tb.sv
module vm_alu_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_wide = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic [15:0] offset = '0;
    logic        out_valid;
    logic [63:0] out_dst;
    logic        out_illegal;
    logic        out_div_req;
    logic        out_div_signed;
    logic [63:0] out_div_opnd;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vm_alu_unit u_dut (
        .clk, .rst_n, .in_valid, .op_wide, .opcode, .dst_val, .src_val,
        .imm, .offset, .out_valid, .out_dst, .out_illegal, .out_div_req,
        .out_div_signed, .out_div_opnd
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [7:0] op, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im, input logic [15:0] of);
        op_wide = w; opcode = op; dst_val = d; src_val = s; imm = im; offset = of;
        in_valid = 1'b1;
    endtask

    // one request, result sampled at the next falling edge
    task automatic exec(input logic w, input logic [7:0] op, input logic [63:0] d,
                        input logic [63:0] s, input logic [31:0] im, input logic [15:0] of);
        @(negedge clk);
        drive(w, op, d, s, im, of);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_ok(input string tag, input logic [63:0] exp);
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " illegal"}, 64'(out_illegal), 64'd0);
        chk({tag, " value"}, out_dst, exp);
    endtask

    task automatic t_reset;
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset dst", out_dst, 64'd0);
        chk("R1 reset flags", {61'd0, out_illegal, out_div_req, out_div_signed}, 64'd0);
        chk("R1 reset opnd", out_div_opnd, 64'd0);
    endtask

    task automatic t_arith;
        exec(1, 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 0);
        expect_ok("R3 add64 wrap", 64'd1);
        exec(0, 8'h08, 64'hAAAA_AAAA_FFFF_FFFF, 64'd2, 0, 0);
        expect_ok("R3 R4 add32 wrap", 64'd1);
        exec(1, 8'h10, 64'd0, 64'd0, 32'd1, 0);
        expect_ok("R3 sub64 wrap", 64'hFFFF_FFFF_FFFF_FFFF);
        exec(1, 8'hA0, 64'h0F0F, 64'd0, 32'h00FF, 0);
        expect_ok("R3 xor imm", 64'h0FF0);
        exec(1, 8'h48, 64'hF0, 64'h0F, 0, 0);
        expect_ok("R3 or reg", 64'hFF);
        exec(1, 8'h5F, 64'hFF, 64'h3C, 0, 0);
        expect_ok("R2 R3 and, low opcode bits ignored", 64'h3C);
    endtask

    task automatic t_operands;
        exec(1, 8'hB0, 64'd7, 64'd0, 32'h8000_0000, 0);
        expect_ok("R5 R8 imm sext64", 64'hFFFF_FFFF_8000_0000);
        exec(0, 8'hB0, 64'd7, 64'd0, 32'h8000_0000, 0);
        expect_ok("R5 R8 imm 32-class", 64'h0000_0000_8000_0000);
        exec(0, 8'hB8, 64'd7, 64'h1234_5678_9ABC_DEF0, 32'h1, 0);
        expect_ok("R2 R4 reg low half", 64'h0000_0000_9ABC_DEF0);
        exec(1, 8'hB8, 64'd7, 64'h1234_5678_9ABC_DEF0, 32'h1, 0);
        expect_ok("R2 R8 reg move64", 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_shifts;
        exec(1, 8'h68, 64'd1, 64'd65, 0, 0);
        expect_ok("R6 lsh64 mask", 64'd2);
        exec(0, 8'h68, 64'h8000_0001, 64'd33, 0, 0);
        expect_ok("R6 lsh32 mask", 64'd2);
        exec(0, 8'h78, 64'hFFFF_FFFF_8000_0000, 64'd4, 0, 0);
        expect_ok("R6 rsh32 zero fill", 64'h0800_0000);
        exec(1, 8'h78, 64'h8000_0000_0000_0000, 64'd127, 0, 0);
        expect_ok("R6 rsh64 mask", 64'd1);
        exec(1, 8'hC8, 64'h8000_0000_0000_0000, 64'd4, 0, 0);
        expect_ok("R7 arsh64", 64'hF800_0000_0000_0000);
        exec(0, 8'hC8, 64'h0000_0000_8000_0000, 64'd4, 0, 0);
        expect_ok("R7 arsh32 neg", 64'h0000_0000_F800_0000);
        exec(0, 8'hC8, 64'h8000_0000_4000_0000, 64'd1, 0, 0);
        expect_ok("R7 arsh32 uses bit31", 64'h2000_0000);
    endtask

    task automatic t_movsx;
        exec(1, 8'hB8, 64'd0, 64'h80, 0, 16'd8);
        expect_ok("R9 sx8 to 64", 64'hFFFF_FFFF_FFFF_FF80);
        exec(1, 8'hB8, 64'd0, 64'h1_7FFF, 0, 16'd16);
        expect_ok("R9 sx16 to 64", 64'h7FFF);
        exec(1, 8'hB8, 64'd0, 64'h0000_0000_8000_0001, 0, 16'd32);
        expect_ok("R9 sx32 to 64", 64'hFFFF_FFFF_8000_0001);
        exec(0, 8'hB8, 64'd0, 64'hFF, 0, 16'd8);
        expect_ok("R10 sx8 to 32", 64'h0000_0000_FFFF_FFFF);
        exec(0, 8'hB0, 64'd0, 64'd0, 32'h8000, 16'd16);
        expect_ok("R10 sx16 imm to 32", 64'h0000_0000_FFFF_8000);
    endtask

    task automatic t_divprep;
        exec(0, 8'h30, 64'h1_0000_0005, 64'd0, 32'hFFFF_FFF0, 0);
        chk("R11 udiv32 req", {62'd0, out_div_req, out_div_signed}, 64'd2);
        chk("R11 udiv32 opnd", out_div_opnd, 64'h0000_0000_FFFF_FFF0);
        chk("R11 udiv32 dst", out_dst, 64'd5);
        exec(1, 8'h30, 64'h1_0000_0005, 64'd0, 32'hFFFF_FFF0, 0);
        chk("R11 udiv64 opnd", out_div_opnd, 64'hFFFF_FFFF_FFFF_FFF0);
        chk("R11 udiv64 dst", out_dst, 64'h1_0000_0005);
        exec(1, 8'h90, 64'd9, 64'd0, 32'h8000_0000, 16'd1);
        chk("R11 smod64 req", {62'd0, out_div_req, out_div_signed}, 64'd3);
        chk("R11 smod64 opnd", out_div_opnd, 64'hFFFF_FFFF_8000_0000);
        exec(0, 8'h38, 64'd9, 64'hABCD_0000_8000_0000, 0, 16'd1);
        chk("R11 sdiv32 reg opnd", out_div_opnd, 64'h0000_0000_8000_0000);
        chk("R11 sdiv32 signed", 64'(out_div_signed), 64'd1);
        exec(1, 8'h08, 64'd1, 64'd1, 0, 0);
        chk("R11 no div on add", {out_div_opnd[62:0], out_div_req}, 64'd0);
    endtask

    task automatic t_illegal;
        exec(1, 8'h30, 64'h1111_2222_3333_4444, 64'd0, 32'd5, 16'd2);
        chk("R12 div off2 illegal", {62'd0, out_illegal, out_div_req}, 64'd2);
        chk("R12 div off2 dst", out_dst, 64'h1111_2222_3333_4444);
        chk("R12 div off2 opnd", out_div_opnd, 64'd0);
        exec(0, 8'h08, 64'hDEAD_0000_0000_0001, 64'd5, 0, 16'd4);
        chk("R12 add offset illegal", 64'(out_illegal), 64'd1);
        chk("R12 add offset dst", out_dst, 64'hDEAD_0000_0000_0001);
        exec(1, 8'h28, 64'h55, 64'd3, 0, 0);
        chk("R12 op 0x2", {out_dst[62:0], out_illegal}, {63'h55, 1'b1});
        exec(1, 8'hD0, 64'h66, 64'd3, 0, 0);
        chk("R12 op 0xd", {out_dst[62:0], out_illegal}, {63'h66, 1'b1});
        exec(1, 8'hB8, 64'h77, 64'hFF, 0, 16'd24);
        chk("R12 move off24", {out_dst[62:0], out_illegal}, {63'h77, 1'b1});
    endtask

    // illegal 32-class move meets zero-fill; back-to-back with a legal op
    task automatic t_collide;
        @(negedge clk);
        drive(0, 8'hB8, 64'hDEAD_BEEF_0123_4567, 64'hFF, 0, 16'd32);
        @(negedge clk);
        chk("R10 sx32 in 32-class illegal", 64'(out_illegal), 64'd1);
        chk("R12 upper half kept", out_dst, 64'hDEAD_BEEF_0123_4567);
        drive(0, 8'h08, 64'hDEAD_BEEF_0000_0010, 64'd1, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 back-to-back valid", 64'(out_valid), 64'd1);
        chk("R4 next op zero-filled", {out_dst[62:0], out_illegal}, {63'h11, 1'b0});
    endtask

    task automatic t_hold;
        @(negedge clk);
        imm = 32'h1234; dst_val = 64'h99;
        @(negedge clk);
        chk("R1 idle no valid", 64'(out_valid), 64'd0);
        chk("R1 idle hold", out_dst, 64'h11);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_arith();
        t_operands();
        t_shifts();
        t_movsx();
        t_divprep();
        t_illegal();
        t_collide();
        t_hold();
        finished = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

endmodule